// File: doc/BRIEF.md
# Power-of-Two Clock Output Divider with Glitch-Free Enable

This block sits behind a high-rate oscillator clock and produces six identical complementary clock pairs at the oscillator rate divided by 1, 2, 4, 8 or 16. A 3-bit code selects the ratio. A new code is adopted only when the divider comes back to the start of its period. The output waveforms therefore stay whole across a ratio change and are always square.

An output-enable input gates all six pairs. The enable is first captured on a rising edge of the source clock and then moved to the output gate on the following falling edge. The gate moves only while the output is low, so neither turning on nor turning off can cut a pulse short.

A master reset, sampled on the rising edge, clears the divider. While it is high, every true output is low and every complement output is high.

Top module: `vco_postdiv`

## Requirements
- R1: While `mreset` is high, every `clk_out_p` bit is 0 and every `clk_out_n` bit is 1.
- R2: With the output enabled and a steady code of 0, 1, 2, 3 or 4, the outputs are square waves of period 2^code source cycles. In half-cycle units, each high run and each low run lasts 2^code half-cycles.
- R3: Codes 5, 6 and 7 give the same waveform as code 4 (divide by 16).
- R4: At all times the six true outputs are identical, and each complement output is the inverse of its true output.
- R5: After `out_en` falls, the outputs finish any high pulse in progress and then stay at true-low/complement-high. The gate never changes state while a divided output is high.
- R6: A change of `out_en` driven after a rising edge reaches the outputs only after the next rising edge and the falling edge that follows it. In divide-by-1 mode, the output therefore still follows the clock through the high half after that rising edge.
- R7: A code change takes effect at the end of the current divide period. Every high or low run is either the full length of the old ratio or the full length of the new ratio, and the new period starts with its high half.
- R8: During reset the active ratio is 2. With `out_en` high and reset released, the outputs are low after the first rising edge that samples reset low. They go high after the second such edge, at the ratio selected by the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Source clock to be divided |
| mreset | input | 1 | Master reset, active high, sampled on the rising edge |
| div_code | input | 3 | Divide select: 0..4 give 2^code, larger values give 16 |
| out_en | input | 1 | Output enable, active high |
| clk_out_p | output | 6 | True clock outputs |
| clk_out_n | output | 6 | Complement clock outputs |

## Verification
A corrupted phase counter or ratio register shows up at the outputs within one divide period, at most 16 source cycles. It appears as a high or low run whose length matches neither the old nor the new ratio, or as asymmetric high and low runs. A stuck or misplaced enable gate shows up within one cycle of an enable change: in divide-by-1 mode, the high half after the first rising edge, and the half-cycles after the following falling edge, expose any early or late gating. A broken pair or fan-out shows up on the first mismatching sample.

// File: rtl/vod_pkg.sv
package vod_pkg;

    localparam int unsigned LOG_MAX = 4;
    localparam int unsigned CNT_W   = LOG_MAX;
    localparam int unsigned K_W     = $clog2(LOG_MAX + 1);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [K_W-1:0]   log_t;

    typedef struct packed {
        cnt_t cnt;
        log_t k;
        logic dq;
    } div_state_t;

    typedef enum logic {
        SRC_DIVIDED = 1'b0,
        SRC_DIRECT  = 1'b1
    } src_sel_e;

    function automatic log_t code_to_log(input logic [7:0] code);
        if (code > 8'(LOG_MAX))
            return log_t'(LOG_MAX);
        return code[K_W-1:0];
    endfunction

    function automatic cnt_t last_count(input log_t k);
        return cnt_t'((32'd1 << k) - 32'd1);
    endfunction

    function automatic cnt_t half_count(input log_t k);
        if (k == '0)
            return '0;
        return cnt_t'(32'd1 << (k - log_t'(1)));
    endfunction

    function automatic logic phase_bit(input cnt_t c, input log_t k);
        if (k == '0)
            return 1'b1;
        return ~c[k - log_t'(1)];
    endfunction

endpackage

// File: rtl/vod_div_core.sv
module vod_div_core
    import vod_pkg::*;
#(
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic              div_q,
    output src_sel_e          src
);

    div_state_t state_q;
    div_state_t state_d;
    logic       wrap;

    always_comb begin
        wrap          = (state_q.cnt == last_count(state_q.k));
        state_d.k     = wrap ? code_to_log(8'(code)) : state_q.k;
        state_d.cnt   = wrap ? '0 : state_q.cnt + cnt_t'(1);
        state_d.dq    = phase_bit(state_d.cnt, state_d.k);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.cnt <= '0;
            state_q.k   <= log_t'(1);
            state_q.dq  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign div_q = state_q.dq;
    assign src   = (state_q.k == '0) ? SRC_DIRECT : SRC_DIVIDED;

    // R2: phase counter never leaves the active period
    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (rst)
        state_q.cnt <= last_count(state_q.k));

    // R7: ratio only moves at a period boundary
    assert_ratio_at_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(state_q.k));

    // R2: output edges only at period start or half point
    assert_edge_points_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q.dq != $past(state_q.dq)) |->
            (state_q.cnt == '0 || state_q.cnt == half_count(state_q.k)));

endmodule

// File: rtl/vod_en_sync.sv
module vod_en_sync
    import vod_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_in,
    input  src_sel_e src,
    input  logic     div_q,
    output logic     gate
);

    logic en_r;
    logic may_move;

    always_ff @(posedge clk) begin
        if (rst)
            en_r <= 1'b0;
        else
            en_r <= en_in;
    end

    assign may_move = (src == SRC_DIRECT) || !div_q;

    always_ff @(negedge clk) begin
        if (rst)
            gate <= 1'b0;
        else if (may_move)
            gate <= en_r;
    end

    // R6: gate only ever moves toward the enable captured on the rising edge
    assert_gate_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (gate != $past(gate)) |-> (gate == en_r));

    // R5: gate frozen while a divided output is high
    assert_gate_hold_high_R5: assert property (@(negedge clk) disable iff (rst)
        (src == SRC_DIVIDED && div_q) |=> $stable(gate));

endmodule

// File: rtl/vod_out_drive.sv
module vod_out_drive
    import vod_pkg::*;
#(
    parameter int unsigned NUM_OUT = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  src_sel_e           src,
    input  logic               div_q,
    input  logic               gate,
    output logic [NUM_OUT-1:0] out_p,
    output logic [NUM_OUT-1:0] out_n
);

    logic raw;

    assign raw = (src == SRC_DIRECT) ? clk : div_q;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_pair
        logic on;
        assign on       = raw & gate & ~rst;
        assign out_p[i] = on;
        assign out_n[i] = ~on;
    end

endmodule

// File: rtl/vco_postdiv.sv
module vco_postdiv
    import vod_pkg::*;
#(
    parameter int unsigned NUM_OUT = 6,
    parameter int unsigned CODE_W  = 3
) (
    input  logic               clk_vco,
    input  logic               mreset,
    input  logic [CODE_W-1:0]  div_code,
    input  logic               out_en,
    output logic [NUM_OUT-1:0] clk_out_p,
    output logic [NUM_OUT-1:0] clk_out_n
);

    logic     div_q;
    src_sel_e src;
    logic     gate;

    vod_div_core #(.CODE_W(CODE_W)) u_core (
        .clk   (clk_vco),
        .rst   (mreset),
        .code  (div_code),
        .div_q (div_q),
        .src   (src)
    );

    vod_en_sync u_sync (
        .clk   (clk_vco),
        .rst   (mreset),
        .en_in (out_en),
        .src   (src),
        .div_q (div_q),
        .gate  (gate)
    );

    vod_out_drive #(.NUM_OUT(NUM_OUT)) u_drive (
        .clk   (clk_vco),
        .rst   (mreset),
        .src   (src),
        .div_q (div_q),
        .gate  (gate),
        .out_p (clk_out_p),
        .out_n (clk_out_n)
    );

    // R1: reset sampled high leaves every pair at true-low
    assert_reset_quiet_R1: assert property (@(posedge clk_vco)
        $past(mreset) && mreset |-> (clk_out_p == '0));

endmodule

// File: tb/vco_postdiv_test.sv
`timescale 1ns/1ps
module vco_postdiv_test;

    logic       clk = 1'b0;
    logic       mreset;
    logic [2:0] div_code;
    logic       out_en;
    logic [5:0] clk_out_p;
    logic [5:0] clk_out_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    vco_postdiv uut (
        .clk_vco   (clk_vco_w),
        .mreset    (mreset),
        .div_code  (div_code),
        .out_en    (out_en),
        .clk_out_p (clk_out_p),
        .clk_out_n (clk_out_n)
    );

    wire clk_vco_w = clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic at_pos();
        @(posedge clk);
        #1;
    endtask

    task automatic at_neg();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) at_pos();
    endtask

    // half-cycle sampler; counts completed runs of clk_out_p[0]
    task automatic collect_runs(input int nruns, input int a, input int b, input string req);
        int   got  = 0;
        int   len  = 0;
        bit   cur;
        bit   first = 1;
        int   bad_pair = 0;
        @(clk);
        #1;
        cur = clk_out_p[0];
        len = 1;
        for (int h = 0; h < 4000 && got < nruns; h++) begin
            @(clk);
            #1;
            // R4: fan-out identical and pairs complementary
            if (!(clk_out_p == {6{clk_out_p[0]}} && clk_out_n == ~clk_out_p))
                bad_pair++;
            if (clk_out_p[0] == cur) begin
                len++;
            end else begin
                if (!first) begin
                    chk(len == a || len == b, req, len, a);
                    got++;
                end
                first = 0;
                cur = clk_out_p[0];
                len = 1;
            end
        end
        chk(got == nruns, req, got, nruns);
        chk(bad_pair == 0, "R4", bad_pair, 0);
    endtask

    initial begin
        #500000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        mreset   = 1'b1;
        div_code = 3'd4;
        out_en   = 1'b1;

        // R1: outputs quiet while reset held
        wait_cycles(2);
        for (int i = 0; i < 6; i++) begin
            @(clk);
            #1;
            chk(clk_out_p == 6'h00, "R1", clk_out_p, 0);
            chk(clk_out_n == 6'h3F, "R1", clk_out_n, 63);
        end

        // R8: release; low after first edge, high after second
        at_pos();
        mreset = 1'b0;
        at_pos();
        chk(clk_out_p == 6'h00, "R8", clk_out_p, 0);
        at_pos();
        chk(clk_out_p == 6'h3F, "R8", clk_out_p, 63);
        collect_runs(4, 16, 16, "R8");

        // R2 / R3: sweep every code
        for (int c = 0; c < 8; c++) begin
            int d;
            d = (c > 4) ? 16 : (1 << c);
            at_pos();
            div_code = 3'(c);
            wait_cycles(40);
            collect_runs(6, d, d, (c > 4) ? "R3" : "R2");
        end

        // R7: ratio changes mid-period
        begin
            int pairs_from [4] = '{4, 1, 0, 3};
            int pairs_to   [4] = '{1, 4, 3, 0};
            for (int j = 0; j < 4; j++) begin
                at_pos();
                div_code = 3'(pairs_from[j]);
                wait_cycles(40);
                wait_cycles(3);
                div_code = 3'(pairs_to[j]);
                collect_runs(10, 1 << pairs_from[j], 1 << pairs_to[j], "R7");
            end
        end

        // R6: enable timing in divide-by-1
        at_pos();
        div_code = 3'd0;
        wait_cycles(10);
        out_en = 1'b0;
        at_pos();
        chk(clk_out_p == 6'h3F, "R6", clk_out_p, 63);
        at_neg();
        chk(clk_out_p == 6'h00, "R6", clk_out_p, 0);
        at_pos();
        chk(clk_out_p == 6'h00, "R5", clk_out_p, 0);
        out_en = 1'b1;
        at_pos();
        chk(clk_out_p == 6'h00, "R6", clk_out_p, 0);
        at_neg();
        chk(clk_out_p == 6'h00, "R6", clk_out_p, 0);
        at_pos();
        chk(clk_out_p == 6'h3F, "R6", clk_out_p, 63);

        // R5: disable in divide-by-16, pulses stay whole
        at_pos();
        div_code = 3'd4;
        wait_cycles(40);
        wait_cycles(2);
        out_en = 1'b0;
        wait_cycles(20);
        for (int i = 0; i < 40; i++) begin
            @(clk);
            #1;
            chk(clk_out_p == 6'h00 && clk_out_n == 6'h3F, "R5", clk_out_p, 0);
        end
        out_en = 1'b1;
        collect_runs(4, 16, 16, "R5");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule